// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between the memory stage of a 32-bit load/store pipeline and a byte-addressable data memory whose port is one 32-bit word wide. On a store it takes the access size, the low bits of the effective address and the register value. It then places the addressed bytes on the matching memory lanes and drives one write enable per lane. On a load it records the size, offset and signedness when the request is issued. One cycle later, when the memory word comes back, it picks out the byte, halfword or word, moves it to the bottom of the result and sign- or zero-extends it.

The byte order is fixed for each run. The ordering input is captured while reset is held and ignored after that. In little-endian order the lowest address of a word is its least significant byte. In big-endian order the lowest address is its most significant byte. An access whose address is not a multiple of its size raises a misalignment flag. A misaligned store writes nothing. Address generation, caching and trap handling belong to other blocks.

Top module: `lsu_lane_unit`

## Requirements
- R1: `cfg_big_endian` is captured on every clock edge while `rst` is high (1 = big-endian, 0 = little-endian). Changing it while `rst` is low has no effect on stores or loads.
- R2: For a valid, aligned store, `mem_be` has exactly one bit set for size code 00 (byte), two adjacent bits for 01 (halfword) and all four bits for 10 or 11 (word). With no valid store in the cycle, `mem_be` is all zero.
- R3: Lane k means `mem_wdata`/`mem_rdata` bits 8k+7..8k. In little-endian order, address offset a (`req_addr_lo`) maps to lane a. In big-endian order it maps to lane 3-a, and the lower-addressed byte of a halfword or word is its most significant byte.
- R4: On a valid, aligned store, each enabled lane carries the corresponding byte of the low bytes of `req_wdata`, and every lane that is not enabled carries zero.
- R5: `misalign` is high in the same cycle as a valid request (load or store) when a halfword has offset bit 0 set or a word has a non-zero offset. Byte accesses are never misaligned.
- R6: A misaligned store drives `mem_be` and `mem_wdata` to all zero.
- R7: `ld_valid` is high exactly in the cycle after a valid load request. In that cycle `ld_data` is formed combinationally from that cycle's `mem_rdata`, using the size, offset and signedness registered with the request.
- R8: A signed byte or halfword load (`req_unsigned` = 0) copies the top bit of the selected field into every higher result bit.
- R9: An unsigned byte or halfword load (`req_unsigned` = 1) fills every higher result bit with zero.
- R10: A word load returns the memory word as it arrives in both byte orders, and `req_unsigned` has no effect on it.
- R11: A misaligned load still raises `ld_valid` one cycle later, with `ld_data` equal to zero.
- R12: After reset, and in any cycle that does not follow a load request, `ld_valid` and `ld_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_big_endian | input | 1 | Byte-order select, captured during reset |
| req_valid | input | 1 | A request is present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend a narrow load |
| req_addr_lo | input | 2 | Byte offset of the effective address within the word |
| req_wdata | input | 32 | Register value to store |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_be | output | 4 | Per-lane write enables |
| misalign | output | 1 | The current request is misaligned |
| mem_rdata | input | 32 | Memory word returned for the previous load |
| ld_valid | output | 1 | `ld_data` holds a load result |
| ld_data | output | 32 | Extended load result |

## Verification
The bench builds the block with the package defaults: four lanes of eight bits. With that geometry every offset and size combination can be enumerated exhaustively, in both byte orders. The run covers a little-endian reset phase and a change of the ordering input without a reset. It then covers a big-endian reset phase, so a stuck or swapped lane map shows up at a specific offset. Random traffic mixes loads and stores back to back, which checks the one-cycle load alignment against memory words that change every cycle.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = LANES * BYTE_W;
    localparam int unsigned OFS_W  = $clog2(LANES);
    localparam int unsigned SPAN_W = OFS_W + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef logic [OFS_W-1:0]  lane_idx_t;
    typedef logic [SPAN_W-1:0] span_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic      valid;
        logic      unsgn;
        logic      misal;
        lane_idx_t lo;
        span_t     span;
    } ld_ctrl_t;

    // number of lanes an access of the given size covers
    function automatic span_t span_of(acc_size_e sz);
        case (sz)
            SZ_BYTE: return span_t'(1);
            SZ_HALF: return span_t'(2);
            default: return span_t'(LANES);
        endcase
    endfunction

    // offset must be a multiple of the span
    function automatic logic is_misaligned(span_t span, lane_idx_t ofs);
        lane_idx_t mask;
        mask = lane_idx_t'(span - span_t'(1));
        return (ofs & mask) != '0;
    endfunction

    // lowest lane occupied by an aligned access
    function automatic lane_idx_t low_lane(logic big, span_t span, lane_idx_t ofs);
        if (!big) begin
            return ofs;
        end
        return lane_idx_t'(span_t'(LANES) - span - {1'b0, ofs});
    endfunction

endpackage

// File: rtl/lsu_lane_plan.sv
module lsu_lane_plan
    import lsu_lane_pkg::*;
(
    input  logic      big,
    input  acc_size_e size,
    input  lane_idx_t ofs,
    output span_t     span,
    output lane_idx_t lo,
    output logic      misal
);

    always_comb begin
        span  = span_of(size);
        misal = is_misaligned(span, ofs);
        lo    = misal ? '0 : low_lane(big, span, ofs);
    end

endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
    import lsu_lane_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  lane_idx_t        lo,
    input  span_t            span,
    input  word_t            src,
    output logic [LANES-1:0] be,
    output word_t            wdata
);

    logic [LANES-1:0][BYTE_W-1:0] src_v;
    assign src_v = src;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic      hit;
        lane_idx_t rel;
        assign rel = lane_idx_t'(i) - lo;
        assign hit = active
                     && (span_t'(i) >= {1'b0, lo})
                     && (span_t'(i) <  ({1'b0, lo} + span));
        assign be[i] = hit;
        assign wdata[i*BYTE_W +: BYTE_W] = hit ? src_v[rel] : '0;
    end

    assert_be_count_R2: assert property (@(posedge clk) disable iff (rst)
        active |-> ($countones(be) == int'(span)));

    assert_be_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !active |-> (be == '0 && wdata == '0));

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ld_ctrl_t ctrl,
    input  word_t    rdata,
    output word_t    result
);

    logic [LANES-1:0][BYTE_W-1:0] rd_v;
    logic [LANES-1:0][BYTE_W-1:0] res_v;
    lane_idx_t                    top_lane;
    logic                         fill;
    logic                         live;

    assign rd_v     = rdata;
    assign top_lane = lane_idx_t'({1'b0, ctrl.lo} + ctrl.span - span_t'(1));
    assign fill     = rd_v[top_lane][BYTE_W-1] & ~ctrl.unsgn;
    assign live     = ctrl.valid & ~ctrl.misal;

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        always_comb begin
            if (!live) begin
                res_v[k] = '0;
            end else if (span_t'(k) < ctrl.span) begin
                res_v[k] = rd_v[lane_idx_t'(ctrl.lo + lane_idx_t'(k))];
            end else begin
                res_v[k] = {BYTE_W{fill}};
            end
        end
    end

    assign result = res_v;

    assert_zero_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (live && ctrl.unsgn && ctrl.span == span_t'(1)) |-> (result[WORD_W-1:BYTE_W] == '0));

    assert_misal_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (ctrl.valid && ctrl.misal) |-> (result == '0));

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_big_endian,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [OFS_W-1:0]  req_addr_lo,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_be,
    output logic              misalign,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [WORD_W-1:0] ld_data
);

    logic      big_q;
    span_t     span;
    lane_idx_t lo;
    logic      plan_misal;
    logic      st_active;
    ld_ctrl_t  ctrl_d;
    ld_ctrl_t  ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            big_q <= cfg_big_endian;
        end
    end

    lsu_lane_plan plan_i (
        .big   (big_q),
        .size  (acc_size_e'(req_size)),
        .ofs   (req_addr_lo),
        .span  (span),
        .lo    (lo),
        .misal (plan_misal)
    );

    assign misalign  = req_valid & plan_misal;
    assign st_active = req_valid & req_is_store & ~plan_misal;

    lsu_store_pack store_i (
        .clk    (clk),
        .rst    (rst),
        .active (st_active),
        .lo     (lo),
        .span   (span),
        .src    (req_wdata),
        .be     (mem_be),
        .wdata  (mem_wdata)
    );

    always_comb begin
        ctrl_d.valid = req_valid & ~req_is_store;
        ctrl_d.unsgn = req_unsigned;
        ctrl_d.misal = plan_misal;
        ctrl_d.lo    = lo;
        ctrl_d.span  = span;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ld_valid = ctrl_q.valid;

    lsu_load_extract load_i (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl_q),
        .rdata  (mem_rdata),
        .result (ld_data)
    );

    assert_ld_follows_req_R7: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(req_valid && !req_is_store));

    assert_misal_store_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_store && misalign) |-> (mem_be == '0 && mem_wdata == '0));

    assert_byte_never_misal_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'b00) |-> !misalign);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> (ld_data == '0));

endmodule

// File: tb/lsu_lane_unit_tb.sv
`timescale 1ns/1ps
module lsu_lane_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [1:0]  req_addr_lo = 2'b00;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        misalign;
    logic [31:0] mem_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // model state
    bit          m_big = 0;
    bit          p_load = 0;
    logic [1:0]  p_sz = 0;
    bit          p_uns = 0;
    logic [1:0]  p_ofs = 0;

    always #10 clk = ~clk;

    lsu_lane_unit dut_i (
        .clk(clk), .rst(rst), .cfg_big_endian(cfg_big_endian),
        .req_valid(req_valid), .req_is_store(req_is_store), .req_size(req_size),
        .req_unsigned(req_unsigned), .req_addr_lo(req_addr_lo), .req_wdata(req_wdata),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .misalign(misalign),
        .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    function automatic int nbytes(logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit ref_mis(logic [1:0] sz, logic [1:0] ofs);
        return (int'(ofs) % nbytes(sz)) != 0;
    endfunction

    // lane holding address a; datum byte index for address a
    function automatic int lane_of(bit big, int a);
        return big ? 3 - a : a;
    endfunction

    function automatic int datum_idx(bit big, int a, int ofs, int n);
        return big ? (n - 1 - (a - ofs)) : (a - ofs);
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", what, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, compare shortly after, then advance the model
    task automatic step(bit v, bit st, logic [1:0] sz, bit uns, logic [1:0] ofs,
                        logic [31:0] wd, logic [31:0] rd);
        logic [3:0]  e_be;
        logic [31:0] e_wd;
        logic [31:0] e_ld;
        bit          e_mis;
        int          n;
        @(negedge clk);
        req_valid = v; req_is_store = st; req_size = sz; req_unsigned = uns;
        req_addr_lo = ofs; req_wdata = wd; mem_rdata = rd;
        #2;
        n = nbytes(sz);
        e_mis = v && ref_mis(sz, ofs);
        e_be = '0; e_wd = '0;
        if (v && st && !e_mis) begin
            for (int a = int'(ofs); a < int'(ofs) + n; a++) begin
                int ln = lane_of(m_big, a);
                int j  = datum_idx(m_big, a, int'(ofs), n);
                e_be[ln] = 1'b1;
                e_wd[ln*8 +: 8] = wd[j*8 +: 8];
            end
        end
        chk("R5 misalign flag", {31'd0, misalign}, {31'd0, e_mis});
        chk("R2/R6 byte enables (R1 order)", {28'd0, mem_be}, {28'd0, e_be});
        chk("R3/R4/R6 write data lanes", mem_wdata, e_wd);
        // load result for the request of the previous cycle
        e_ld = '0;
        if (p_load && !ref_mis(p_sz, p_ofs)) begin
            int pn = nbytes(p_sz);
            for (int a = int'(p_ofs); a < int'(p_ofs) + pn; a++) begin
                int ln = lane_of(m_big, a);
                int j  = datum_idx(m_big, a, int'(p_ofs), pn);
                e_ld[j*8 +: 8] = rd[ln*8 +: 8];
            end
            if (pn < 4 && !p_uns && e_ld[pn*8-1]) begin
                for (int b = pn*8; b < 32; b++) e_ld[b] = 1'b1;
            end
        end
        chk("R7/R12 load valid", {31'd0, ld_valid}, {31'd0, p_load});
        chk("R8/R9/R10/R11/R12 load data", ld_data, e_ld);
        p_load = v && !st; p_sz = sz; p_uns = uns; p_ofs = ofs;
    endtask

    task automatic do_reset(bit big);
        @(negedge clk);
        rst = 1'b1; cfg_big_endian = big; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_big = big;
        p_load = 0;
        #2;
        chk("R12 reset ld_valid", {31'd0, ld_valid}, 32'd0);
        chk("R12 reset ld_data", ld_data, 32'd0);
        chk("R2 reset enables", {28'd0, mem_be}, 32'd0);
    endtask

    task automatic directed();
        for (int sz = 0; sz < 4; sz++) begin
            for (int o = 0; o < 4; o++) begin
                step(1, 1, 2'(sz), 0, 2'(o), 32'hA1B2C3D4, 32'h0);
                step(1, 0, 2'(sz), 0, 2'(o), 32'h0, 32'h0);
                step(1, 0, 2'(sz), 1, 2'(o), 32'h0, 32'h8F7E6D5C);
                step(0, 0, 2'(sz), 0, 2'(o), 32'h0, 32'hF08192A3);
            end
        end
        // sign bit set in every lane, signed vs unsigned (R8, R9), word ignores unsigned (R10)
        for (int o = 0; o < 4; o++) begin
            step(1, 0, 2'd0, 0, 2'(o), 32'h0, 32'h0);
            step(1, 0, 2'd0, 1, 2'(o), 32'h0, 32'h80C0E0F0);
            step(1, 0, 2'd1, 0, 2'(o & 2), 32'h0, 32'h80C0E0F0);
            step(1, 0, 2'd2, 1, 2'd0, 32'h0, 32'h7F018081);
            step(0, 0, 2'd0, 0, 2'd0, 32'h0, 32'hFFFFFFFF);
        end
    endtask

    task automatic random_run(int cycles);
        for (int c = 0; c < cycles; c++) begin
            step(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), $urandom, $urandom);
        end
    endtask

    initial begin
        do_reset(0);
        directed();
        random_run(400);
        // R1: ordering input changes without reset; model stays little-endian
        @(negedge clk);
        cfg_big_endian = 1'b1;
        directed();
        random_run(200);
        do_reset(1);
        directed();
        random_run(400);
        step(0, 0, 2'd0, 0, 2'd0, 32'h0, 32'h0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule